// File: doc/BRIEF.md
# Cascaded digital noise-shaping modulator

This block reduces a 16-bit signed sample stream to a short signed word for a few-level oversampled DAC. It pushes the truncation noise out of the signal band with a two-stage cascade. The first stage is a second-order error-feedback quantizer that keeps only the coarse part of its internal sum. The low part it discards is the first-stage error, and the second stage requantizes that error with first-order error feedback. A digital recombination filter then takes the second stage's coarse word through two cascaded first differences and adds it to the time-aligned first-stage word. The first-stage error cancels exactly. What remains is the signal plus the second-stage error shaped by (1 - z^-1)^3.

Every arithmetic step is an exact integer operation, so the output stream is a bit-true function of the input stream. The block advances one sample per cycle in which `valid_i` is high and keeps all of its state through cycles in which it is low.

Top module: `mash_shaper`

## Requirements
- R1: While `rst_ni` is low and on the first sampling point after its release, `valid_o` is 0 and `data_o` is 0. All error and difference history is cleared to zero.
- R2: A sample accepted on a rising edge with `valid_i` high appears on `data_o`, with `valid_o` high, after the third rising edge counted from that edge. A cycle with `valid_i` low gives `valid_o` low three edges later.
- R3: Coarse stage: with e1 the 15-bit unsigned error history, u1 = x + 2*e1[n-1] - e1[n-2], y1 = floor(u1 / 32768), and e1[n] = u1 mod 32768 (the low 15 bits of u1).
- R4: Fine stage: the input is e1[n]. u2 = e1[n] + e2[n-1], y2 = floor(u2 / 32768), and e2[n] = u2 mod 32768.
- R5: The output is data_o[n] = y1[n] + y2[n] - 2*y2[n-1] + y2[n-2], as a 4-bit two's-complement value. This makes data_o*32768 equal to x plus (1 - z^-1)^3 applied to the fine-stage error.
- R6: In cycles with `valid_i` low, `data_i` is ignored and no history changes. A stream sent with idle gaps gives the same output values as the same stream sent back to back, and `data_o` holds its last value while `valid_o` is low.
- R7: For every input sequence, including alternating full-scale extremes, the output lies in [-4, 4] and no internal sum wraps around.
- R8: Starting from reset with a constant input x held for 1024 samples, the sum S of the 1024 outputs satisfies |S*32768 - 1024*x| <= 4*32768, so the running mean tracks x/32768 far inside one output step.
- R9: The first output after reset equals floor(x0 / 32768) for the first input x0: -1 for -32768, and 0 for 20000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, oversampled rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | 16 | Signed two's-complement input sample |
| valid_o | output | 1 | Output word strobe |
| data_o | output | 4 | Signed shaped output word |

## Verification
The hardest case to reach from the ports is an idle cycle that arrives while a sample is still in flight. Here the coarse stage must freeze while the fine stage and the recombination filter still complete the previous sample, and each history register must step only with its own stage's strobe. The stimulus replays a pseudo-random stream with one- and two-cycle gaps, and drives junk on `data_i` during the gaps. The scoreboard expects exactly the values of the gapless stream. Alternating full-scale inputs drive the coarse stage to its extreme codes at the same time as the fine stage carries, which checks the output range and the absence of wraparound.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int unsigned COARSE_ORD = 2;
  localparam int unsigned FINE_ORD   = 1;

  // coarse word width for an error-feedback stage of the given order
  function automatic int unsigned stage_yw(input int unsigned ord);
    return ord + 2;
  endfunction
endpackage

// File: rtl/mash_ef_stage.sv
module mash_ef_stage #(
  parameter int unsigned IN_W    = 16,
  parameter int unsigned STEP_SH = 15,
  parameter int unsigned ORDER   = 2,
  parameter int unsigned Y_W     = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic signed [IN_W-1:0]     x_i,
  output logic                       valid_o,
  output logic signed [Y_W-1:0]      y_o,
  output logic        [STEP_SH-1:0]  err_o
);
  localparam int unsigned U_W = IN_W + 3;

  logic signed [U_W-1:0]   x_ext, u_w, y_w;
  logic        [STEP_SH-1:0] e_w;
  logic        [STEP_SH-1:0] hist_q [ORDER];
  logic signed [Y_W-1:0]   y_q;
  logic                    v_q;

  assign x_ext = U_W'(x_i);

  // u = x - sum a_k q[n-k], with q = -e (error stored as discarded low part)
  if (ORDER == 1) begin : g_ord1
    assign u_w = x_ext + U_W'($signed({1'b0, hist_q[0]}));
  end else begin : g_ord2
    assign u_w = x_ext + (U_W'($signed({1'b0, hist_q[0]})) <<< 1)
                       - U_W'($signed({1'b0, hist_q[1]}));
  end

  assign y_w = u_w >>> STEP_SH;
  assign e_w = u_w[STEP_SH-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(ORDER); k++) hist_q[k] <= '0;
      y_q <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        hist_q[0] <= e_w;
        for (int k = 1; k < int'(ORDER); k++) hist_q[k] <= hist_q[k-1];
        y_q <= y_w[Y_W-1:0];
      end
    end
  end

  assign valid_o = v_q;
  assign y_o     = y_q;
  assign err_o   = hist_q[0];

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($signed(y_w) == $signed(y_w[Y_W-1:0]))); // R7

  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hist_q[0])); // R6

  AST_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_q)); // R6
endmodule

// File: rtl/mash_cancel.sv
module mash_cancel #(
  parameter int unsigned A_W   = 4,
  parameter int unsigned B_W   = 3,
  parameter int unsigned OUT_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [A_W-1:0]    a_i,
  input  logic signed [B_W-1:0]    b_i,
  output logic                     valid_o,
  output logic signed [OUT_W-1:0]  out_o
);
  localparam int unsigned S_W = ((A_W > B_W + 2) ? A_W : B_W + 2) + 1;

  logic signed [B_W-1:0]   bp_q;
  logic signed [S_W-1:0]   d1p_q;
  logic signed [S_W-1:0]   d1_w, d2_w, sum_w;
  logic signed [OUT_W-1:0] out_q;
  logic                    v_q;

  // two cascaded first differences: (1 - z^-1)^2
  assign d1_w  = S_W'(b_i) - S_W'(bp_q);
  assign d2_w  = d1_w - d1p_q;
  assign sum_w = S_W'(a_i) + d2_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q  <= '0;
      d1p_q <= '0;
      out_q <= '0;
      v_q   <= 1'b0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        bp_q  <= b_i;
        d1p_q <= d1_w;
        out_q <= sum_w[OUT_W-1:0];
      end
    end
  end

  assign valid_o = v_q;
  assign out_o   = out_q;

  AST_SUM_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($signed(sum_w) == $signed(sum_w[OUT_W-1:0]))); // R7

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(out_q)); // R6
endmodule

// File: rtl/mash_shaper.sv
module mash_shaper
  import mash_pkg::*;
#(
  parameter int unsigned DIN_W = 16,
  parameter int unsigned OUT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DIN_W-1:0]  data_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  data_o
);
  localparam int unsigned STEP_SH = DIN_W - 1;
  localparam int unsigned Y1_W    = stage_yw(COARSE_ORD);
  localparam int unsigned Y2_W    = stage_yw(FINE_ORD);
  localparam int          OUT_LIM = (1 << COARSE_ORD) + (1 << COARSE_ORD) - 4;

  logic                      v1, v2, v3;
  logic signed [Y1_W-1:0]    y1, y1_d;
  logic signed [Y2_W-1:0]    y2;
  logic        [STEP_SH-1:0] e1, e2;
  logic signed [OUT_W-1:0]   out_w;

  mash_ef_stage #(
    .IN_W(DIN_W), .STEP_SH(STEP_SH), .ORDER(COARSE_ORD), .Y_W(Y1_W)
  ) u_coarse (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .x_i($signed(data_i)),
    .valid_o(v1), .y_o(y1), .err_o(e1)
  );

  mash_ef_stage #(
    .IN_W(DIN_W), .STEP_SH(STEP_SH), .ORDER(FINE_ORD), .Y_W(Y2_W)
  ) u_fine (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(v1), .x_i($signed({1'b0, e1})),
    .valid_o(v2), .y_o(y2), .err_o(e2)
  );

  // align coarse word with the fine stage's register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  y1_d <= '0;
    else if (v1)  y1_d <= y1;
  end

  mash_cancel #(
    .A_W(Y1_W), .B_W(Y2_W), .OUT_W(OUT_W)
  ) u_cancel (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(v2), .a_i(y1_d), .b_i(y2),
    .valid_o(v3), .out_o(out_w)
  );

  assign valid_o = v3;
  assign data_o  = out_w;

  AST_LAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##3 valid_o); // R2

  AST_LAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##3 !valid_o); // R2

  AST_OUT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($signed(data_o) >= -OUT_LIM && $signed(data_o) <= OUT_LIM)); // R7

  AST_FINE_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2 |-> ($signed(y2) >= 0)); // R4
endmodule

// File: tb/sim_mash_shaper.sv
module sim_mash_shaper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        valid_o;
  logic [3:0]  data_o;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_q[$];
  string tag_q[$];
  longint acc_sum = 0;
  int acc_cnt = 0;
  int seed = 32'h1234abcd;
  int e1a = 0, e1b = 0, e2a = 0, y2a = 0, y2b = 0;
  int rnd_save[200];

  always #(CLK_PERIOD/2) clk = ~clk;

  mash_shaper u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bit-true model of the difference equations (R3, R4, R5)
  function automatic int ref_step(input int x);
    int u1, y1, e1, u2, y2, o;
    u1 = x + 2 * e1a - e1b;
    y1 = u1 >>> 15;
    e1 = u1 & 32'h7fff;
    u2 = e1 + e2a;
    y2 = u2 >>> 15;
    o  = y1 + y2 - 2 * y2a + y2b;
    e1b = e1a; e1a = e1;
    e2a = u2 & 32'h7fff;
    y2b = y2a; y2a = y2;
    return o;
  endfunction

  function automatic int next_rand();
    logic [15:0] r;
    seed = seed * 1103515245 + 12345;
    r = seed[23:8];
    return int'($signed(r));
  endfunction

  task automatic send(input int x, input string tag);
    @(negedge clk);
    valid_i = 1'b1;
    data_i  = 16'(x);
    exp_q.push_back(ref_step(x));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      data_i  = 16'(next_rand());
    end
  endtask

  task automatic drain();
    idle(1);
    while (exp_q.size() != 0) @(negedge clk);
    idle(2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    valid_i = 1'b0;
    rst_n = 1'b0;
    e1a = 0; e1b = 0; e2a = 0; y2a = 0; y2b = 0;
    acc_sum = 0; acc_cnt = 0;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0 && data_o == 4'd0, "R1 in reset", int'(data_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b0, "R1 valid after release", int'(valid_o), 0);
    check(data_o == 4'd0, "R1 data after release", int'($signed(data_o)), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    int e;
    string t;
    if (rst_n && valid_o) begin
      acc_sum += longint'($signed(data_o));
      acc_cnt++;
      check($signed(data_o) >= -4 && $signed(data_o) <= 4, "R7 range",
            int'($signed(data_o)), 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected output", int'($signed(data_o)), 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'($signed(data_o)) == e, t, int'($signed(data_o)), e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    longint dev;
    do_reset();

    // R9: first output from zero history
    send(20000, "R9 first output");
    // R2: exact latency, sampled after each edge
    @(negedge clk); valid_i = 1'b0;
    check(valid_o == 1'b0, "R2 after edge 1", int'(valid_o), 0);
    @(negedge clk);
    check(valid_o == 1'b0, "R2 after edge 2", int'(valid_o), 0);
    @(negedge clk);
    check(valid_o == 1'b1, "R2 after edge 3", int'(valid_o), 1);
    check($signed(data_o) == 0, "R9 value 20000", int'($signed(data_o)), 0);
    drain();

    do_reset();
    send(-32768, "R9 first output");
    drain();
    check(acc_cnt == 1 && acc_sum == -1, "R9 value -32768", int'(acc_sum), -1);

    // ramp: R3, R4, R5
    do_reset();
    for (int i = 0; i < 64; i++) send(-32768 + i * 1021, "R3,R4,R5 ramp");
    drain();

    // alternating full scale: R7
    do_reset();
    for (int i = 0; i < 64; i++) send((i % 2) ? 32767 : -32768, "R7 full scale");
    for (int i = 0; i < 32; i++) send((i % 4 < 2) ? 32767 : -32768, "R7 full scale");
    for (int i = 0; i < 32; i++) send(32767, "R7 positive rail");
    drain();

    // random stream back to back, then replayed with gaps: R6
    do_reset();
    for (int i = 0; i < 200; i++) begin
      rnd_save[i] = next_rand();
      send(rnd_save[i], "R3,R4,R5 random");
    end
    drain();
    do_reset();
    for (int i = 0; i < 200; i++) begin
      send(rnd_save[i], "R6 gapped replay");
      if (i % 3 == 1) idle(1);
      else if (i % 7 == 0) idle(2);
    end
    // R6: output holds while valid_o low
    drain();
    begin
      logic [3:0] held;
      held = data_o;
      idle(4);
      check(data_o == held && valid_o == 1'b0, "R6 hold",
            int'($signed(data_o)), int'($signed(held)));
    end

    // R8: mean of a constant input
    do_reset();
    for (int i = 0; i < 1024; i++) send(12345, "R8 constant");
    drain();
    dev = acc_sum * 32768 - longint'(1024) * 12345;
    if (dev < 0) dev = -dev;
    check(acc_cnt == 1024 && dev <= 4 * 32768, "R8 mean", int'(acc_sum),
          (1024 * 12345) / 32768);

    do_reset();
    for (int i = 0; i < 1024; i++) send(-7000, "R8 constant");
    drain();
    dev = acc_sum * 32768 + longint'(1024) * 7000;
    if (dev < 0) dev = -dev;
    check(acc_cnt == 1024 && dev <= 4 * 32768, "R8 mean negative", int'(acc_sum),
          -(1024 * 7000) / 32768);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule